// File: doc/BRIEF.md
# Dual Audio Sample FIFO

This block sits between a host-side data port (register accesses or a DMA engine) and a serial audio framer. It holds two 32-bit word queues of 16 entries each: one for playback, drained by the framer one sample at a time, and one for capture, filled by the framer one sample at a time. Between the words and the framer's samples it applies a selectable format. A sample can be LSB-aligned 16, 20 or 24 bits, a full 32-bit word, or packed, where two 16-bit samples share one word.

Each direction has its own run enable, flush strobe, occupancy field and attention threshold. The threshold raises a service request for the DMA engine. Status outputs report ready (threshold met), busy (data in flight) and a sticky error for playback underrun or capture overrun. Each error has its own interrupt enable. A loopback switch sends the playback samples the framer takes into the capture path.

All data moves on valid/ready streams. Host writes are accepted only while the playback queue has a free slot (`host_wready` low applies back-pressure). Captured words stay on `host_rdata` with `host_rvalid` high until `host_rready` takes them. The framer pulls playback samples with `tx_smp_ready`, and a pull that finds no sample is an underrun. The capture sample stream has no ready: the framer cannot be stalled, so a word that completes while the queue is full is dropped and flagged.

Top module: `dual_audio_fifo`

## Requirements
- R1: The playback queue accepts a host word whenever fewer than 16 words are held (`host_wready` high). It offers the samples to the framer in write order only while `tx_enable` is high. With `tx_enable` low, `tx_smp_valid` stays low and the contents are kept.
- R2: While `rx_enable` is high, captured samples are formatted and delivered to the host in arrival order, each held until `host_rready` takes it. With `rx_enable` low, incoming samples are ignored and nothing is stored.
- R3: `tx_slots` reports the number of empty playback slots and `rx_slots` the number of filled capture slots, both 6 bits wide. After reset they read 16 and 0, no valid is asserted, and both error flags are 0.
- R4: The attention code maps 0, 1, 2 and 3 to 1, 4, 8 and 12 slots. `tx_ready` is high when empty playback slots are at least that level, and `rx_ready` is high when filled capture slots are at least that level. Each request output is its ready flag gated by its request enable.
- R5: A one-cycle flush strobe empties its queue at the next clock edge. After a playback flush `tx_slots` reads 16. A capture flush leaves `rx_slots` at 0 and discards a half-assembled packed word.
- R6: Format codes 0, 1 and 2 select 16-, 20- and 24-bit LSB-aligned samples, and code 3 selects full 32-bit samples (codes 4 to 6 act as 3). On playback, the sample is the word with the bits above the width cleared. On capture, the stored word is the sample with those bits cleared.
- R7: Format code 7 is packed. On playback, each word yields two samples: bits 15:0 first (left), then bits 31:16 (right), each zero-extended. On capture, the first sample's low 16 bits fill word bits 15:0, and the second sample's low 16 bits fill bits 31:16. The word is stored when the second sample arrives.
- R8: The playback error flag sets when the framer asserts `tx_smp_ready` while `tx_enable` is high and no sample is available. The capture error flag sets when a complete word arrives while the capture queue is full, and that word is dropped. The flags stay set until a clear strobe; a set in the same cycle wins. Each interrupt output is its flag gated by its enable.
- R9: With `loop_enable` high, the capture path takes exactly the samples the framer takes from playback, and `rx_smp_valid`/`rx_smp_data` are ignored.
- R10: `tx_busy` is high when `tx_enable` is high and a playback word is held. `rx_busy` is high when a capture word is held or a packed half is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_enable | input | 1 | Playback run enable |
| rx_enable | input | 1 | Capture run enable |
| tx_flush | input | 1 | Playback flush strobe |
| rx_flush | input | 1 | Capture flush strobe |
| tx_atn_lvl | input | 2 | Playback attention code |
| rx_atn_lvl | input | 2 | Capture attention code |
| word_fmt | input | 3 | Sample format code |
| loop_enable | input | 1 | Route playback samples into capture |
| tx_req_en | input | 1 | Playback request enable |
| rx_req_en | input | 1 | Capture request enable |
| tx_err_ie | input | 1 | Playback error interrupt enable |
| rx_err_ie | input | 1 | Capture error interrupt enable |
| tx_err_clr | input | 1 | Playback error clear strobe |
| rx_err_clr | input | 1 | Capture error clear strobe |
| host_wvalid | input | 1 | Host playback word valid |
| host_wready | output | 1 | Playback queue can take a word |
| host_wdata | input | 32 | Host playback word |
| host_rvalid | output | 1 | Capture word available |
| host_rready | input | 1 | Host takes capture word |
| host_rdata | output | 32 | Capture word |
| tx_smp_valid | output | 1 | Playback sample available |
| tx_smp_ready | input | 1 | Framer takes playback sample |
| tx_smp_data | output | 32 | Playback sample |
| rx_smp_valid | input | 1 | Framer capture sample strobe |
| rx_smp_data | input | 32 | Framer capture sample |
| tx_slots | output | 6 | Empty playback slots |
| rx_slots | output | 6 | Filled capture slots |
| tx_ready | output | 1 | Playback attention met |
| rx_ready | output | 1 | Capture attention met |
| tx_busy | output | 1 | Playback data in flight |
| rx_busy | output | 1 | Capture data in flight |
| tx_req | output | 1 | Playback service request |
| rx_req | output | 1 | Capture service request |
| tx_err | output | 1 | Playback underrun flag |
| rx_err | output | 1 | Capture overrun flag |
| tx_err_irq | output | 1 | Playback error interrupt |
| rx_err_irq | output | 1 | Capture error interrupt |

## Verification
The hardest situation to reach is a capture overrun. The word must complete at the exact moment the queue holds 16 entries, and the dropped word must not reappear later. The stimulus holds `host_rready` low while 16 full-width samples arrive, checks the attention boundary at 11 and 12 entries on the way, and then sends a seventeenth sample. After that, the queue drains, and the scoreboard shows that exactly the first sixteen words come out. A packed half left pending across a capture flush is also set up on purpose, so that the next pair forms a word from the new samples only.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int LVL_W  = 5;

  localparam logic [2:0] FMT_LSB16 = 3'd0;
  localparam logic [2:0] FMT_LSB20 = 3'd1;
  localparam logic [2:0] FMT_LSB24 = 3'd2;
  localparam logic [2:0] FMT_FULL  = 3'd3;
  localparam logic [2:0] FMT_PAIR  = 3'd7;

  // keep mask for the LSB-aligned formats; unknown codes keep the whole word
  function automatic logic [WORD_W-1:0] fmt_mask(input logic [2:0] f);
    case (f)
      FMT_LSB16: fmt_mask = 32'h0000_FFFF;
      FMT_LSB20: fmt_mask = 32'h000F_FFFF;
      FMT_LSB24: fmt_mask = 32'h00FF_FFFF;
      default:   fmt_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // attention code to slot count
  function automatic logic [LVL_W-1:0] atn_slots(input logic [1:0] c);
    case (c)
      2'd0:    atn_slots = 5'd1;
      2'd1:    atn_slots = 5'd4;
      2'd2:    atn_slots = 5'd8;
      default: atn_slots = 5'd12;
    endcase
  endfunction
endpackage

// File: rtl/audfifo_queue.sv
module audfifo_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= wdata;
  end

  // R5: a flush leaves the queue empty on the next cycle
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
  // R1: a full queue stays full while nothing drains it
  a_r1_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !clr) |=> full);
endmodule

// File: rtl/audfifo_tx_unpack.sv
module audfifo_tx_unpack
  import audfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [2:0]        fmt,
  input  logic [WORD_W-1:0] word,
  input  logic              word_avail,
  input  logic              smp_ready,
  output logic              smp_valid,
  output logic [WORD_W-1:0] smp_data,
  output logic              word_pop,
  output logic              underrun
);
  logic upper_q;
  logic pair;
  logic take;

  assign pair      = (fmt == FMT_PAIR);
  assign smp_valid = en & word_avail;
  assign take      = smp_valid & smp_ready;
  assign word_pop  = take & (~pair | upper_q);
  assign underrun  = en & smp_ready & ~word_avail;

  always_comb begin
    if (pair) begin
      if (upper_q) smp_data = {{(WORD_W-HALF_W){1'b0}}, word[WORD_W-1 -: HALF_W]};
      else         smp_data = {{(WORD_W-HALF_W){1'b0}}, word[HALF_W-1:0]};
    end else begin
      smp_data = word & fmt_mask(fmt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            upper_q <= 1'b0;
    else if (clr)          upper_q <= 1'b0;
    else if (take && pair) upper_q <= ~upper_q;
  end

  // R7: after the left half leaves, the same word stays at the queue head
  a_r7_word_kept_for_right: assert property (@(posedge clk) disable iff (!rst_n)
    (pair && take && !upper_q && !clr) |=> $stable(word));
  // R6: 16-bit samples carry no bits above bit 15
  a_r6_lsb16_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && fmt == FMT_LSB16) |-> (smp_data[WORD_W-1:HALF_W] == '0));
  // R8: an underrun never consumes a word
  a_r8_underrun_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !word_pop);
endmodule

// File: rtl/audfifo_rx_pack.sv
module audfifo_rx_pack
  import audfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [2:0]        fmt,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_data,
  input  logic              fifo_full,
  output logic              word_push,
  output logic [WORD_W-1:0] word_data,
  output logic              overrun,
  output logic              half_pending
);
  logic              upper_q;
  logic [HALF_W-1:0] low_q;
  logic              pair;
  logic              acc;
  logic              complete;

  assign pair         = (fmt == FMT_PAIR);
  assign acc          = en & smp_valid;
  assign complete     = acc & (~pair | upper_q);
  assign word_push    = complete & ~fifo_full;
  assign overrun      = complete & fifo_full;
  assign half_pending = upper_q;
  assign word_data    = pair ? {smp_data[HALF_W-1:0], low_q} : (smp_data & fmt_mask(fmt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= 1'b0;
      low_q   <= '0;
    end else if (clr) begin
      upper_q <= 1'b0;
    end else if (acc && pair) begin
      if (!upper_q) low_q <= smp_data[HALF_W-1:0];
      upper_q <= ~upper_q;
    end
  end

  // R2: nothing is stored while capture is stopped
  a_r2_off_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !word_push);
  // R8: a full queue never receives a word
  a_r8_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !word_push);
endmodule

// File: rtl/audfifo_sticky.sv
module audfifo_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag & ie;

  // R8: set beats clear, and the flag persists until cleared
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/dual_audio_fifo.sv
module dual_audio_fifo
  import audfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              rx_enable,
  input  logic              tx_flush,
  input  logic              rx_flush,
  input  logic [1:0]        tx_atn_lvl,
  input  logic [1:0]        rx_atn_lvl,
  input  logic [2:0]        word_fmt,
  input  logic              loop_enable,
  input  logic              tx_req_en,
  input  logic              rx_req_en,
  input  logic              tx_err_ie,
  input  logic              rx_err_ie,
  input  logic              tx_err_clr,
  input  logic              rx_err_clr,
  input  logic              host_wvalid,
  output logic              host_wready,
  input  logic [WORD_W-1:0] host_wdata,
  output logic              host_rvalid,
  input  logic              host_rready,
  output logic [WORD_W-1:0] host_rdata,
  output logic              tx_smp_valid,
  input  logic              tx_smp_ready,
  output logic [WORD_W-1:0] tx_smp_data,
  input  logic              rx_smp_valid,
  input  logic [WORD_W-1:0] rx_smp_data,
  output logic [CNT_W-1:0]  tx_slots,
  output logic [CNT_W-1:0]  rx_slots,
  output logic              tx_ready,
  output logic              rx_ready,
  output logic              tx_busy,
  output logic              rx_busy,
  output logic              tx_req,
  output logic              rx_req,
  output logic              tx_err,
  output logic              rx_err,
  output logic              tx_err_irq,
  output logic              rx_err_irq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // playback side
  logic [WORD_W-1:0] txq_rdata;
  logic [CNT_W-1:0]  txq_cnt;
  logic              txq_full, txq_empty, txq_pop, tx_under;

  audfifo_queue #(.W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_flush),
    .push(host_wvalid), .wdata(host_wdata),
    .pop(txq_pop), .rdata(txq_rdata),
    .count(txq_cnt), .full(txq_full), .empty(txq_empty)
  );

  audfifo_tx_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .clr(tx_flush), .en(tx_enable), .fmt(word_fmt),
    .word(txq_rdata), .word_avail(~txq_empty), .smp_ready(tx_smp_ready),
    .smp_valid(tx_smp_valid), .smp_data(tx_smp_data),
    .word_pop(txq_pop), .underrun(tx_under)
  );

  assign host_wready = ~txq_full;

  // capture side, with the loopback source select
  logic              cap_valid;
  logic [WORD_W-1:0] cap_data;
  logic              rxq_push, rxq_full, rxq_empty, rx_over, rx_half;
  logic [WORD_W-1:0] rxq_wdata;
  logic [CNT_W-1:0]  rxq_cnt;

  assign cap_valid = loop_enable ? (tx_smp_valid & tx_smp_ready) : rx_smp_valid;
  assign cap_data  = loop_enable ? tx_smp_data : rx_smp_data;

  audfifo_rx_pack u_pack (
    .clk(clk), .rst_n(rst_n), .clr(rx_flush), .en(rx_enable), .fmt(word_fmt),
    .smp_valid(cap_valid), .smp_data(cap_data), .fifo_full(rxq_full),
    .word_push(rxq_push), .word_data(rxq_wdata),
    .overrun(rx_over), .half_pending(rx_half)
  );

  audfifo_queue #(.W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_flush),
    .push(rxq_push), .wdata(rxq_wdata),
    .pop(host_rready), .rdata(host_rdata),
    .count(rxq_cnt), .full(rxq_full), .empty(rxq_empty)
  );

  assign host_rvalid = ~rxq_empty;

  // occupancy, attention and activity
  assign tx_slots = FULL_CNT - txq_cnt;
  assign rx_slots = rxq_cnt;
  assign tx_ready = (tx_slots >= CNT_W'(atn_slots(tx_atn_lvl)));
  assign rx_ready = (rx_slots >= CNT_W'(atn_slots(rx_atn_lvl)));
  assign tx_req   = tx_ready & tx_req_en;
  assign rx_req   = rx_ready & rx_req_en;
  assign tx_busy  = tx_enable & ~txq_empty;
  assign rx_busy  = ~rxq_empty | rx_half;

  // error flags, one per direction (index 0 playback, 1 capture)
  logic [1:0] err_set, err_clr, err_ie, err_q, err_int;
  assign err_set = {rx_over, tx_under};
  assign err_clr = {rx_err_clr, tx_err_clr};
  assign err_ie  = {rx_err_ie, tx_err_ie};

  for (genvar g = 0; g < 2; g++) begin : g_err
    audfifo_sticky u_flag (
      .clk(clk), .rst_n(rst_n), .set(err_set[g]), .clr(err_clr[g]),
      .ie(err_ie[g]), .flag(err_q[g]), .irq(err_int[g])
    );
  end

  assign tx_err     = err_q[0];
  assign rx_err     = err_q[1];
  assign tx_err_irq = err_int[0];
  assign rx_err_irq = err_int[1];

  // R3: occupancy fields never exceed the depth
  a_r3_slots_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_slots <= FULL_CNT) && (rx_slots <= FULL_CNT));
  // R9: in loopback the framer capture strobe cannot reach the queue
  a_r9_loop_ignores_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_enable && !(tx_smp_valid && tx_smp_ready) && !rx_half) |-> !rxq_push);
endmodule

// File: tb/dual_audio_fifo_bench.sv
module dual_audio_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_enable = 0, rx_enable = 0, tx_flush = 0, rx_flush = 0;
  logic [1:0]  tx_atn_lvl = 0, rx_atn_lvl = 0;
  logic [2:0]  word_fmt = 3'd3;
  logic        loop_enable = 0, tx_req_en = 0, rx_req_en = 0;
  logic        tx_err_ie = 0, rx_err_ie = 0, tx_err_clr = 0, rx_err_clr = 0;
  logic        host_wvalid = 0, host_rready = 0, tx_smp_ready = 0, rx_smp_valid = 0;
  logic [31:0] host_wdata = 0, rx_smp_data = 0;
  logic        host_wready, host_rvalid, tx_smp_valid;
  logic [31:0] host_rdata, tx_smp_data;
  logic [5:0]  tx_slots, rx_slots;
  logic        tx_ready, rx_ready, tx_busy, rx_busy, tx_req, rx_req;
  logic        tx_err, rx_err, tx_err_irq, rx_err_irq;

  dual_audio_fifo u_dual_audio_fifo (.*);

  always #10 clk = ~clk;

  int nvec = 0, nmis = 0;
  bit done = 0;
  logic [31:0] txq[$], rxq[$];
  bit          bh = 0;
  logic [15:0] blo = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bmask(input logic [2:0] f);
    case (f)
      3'd0:    return 32'h0000_FFFF;
      3'd1:    return 32'h000F_FFFF;
      3'd2:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // driver: host word write, expectations from R1/R6/R7 (and R9 when looped)
  task automatic wr(input logic [31:0] w, input bit exp_tx, input bit exp_rx);
    @(posedge clk); #1;
    host_wvalid = 1; host_wdata = w;
    while (!host_wready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    host_wvalid = 0;
    if (exp_tx) begin
      if (word_fmt == 3'd7) begin
        txq.push_back({16'h0, w[15:0]});
        txq.push_back({16'h0, w[31:16]});
      end else txq.push_back(w & bmask(word_fmt));
    end
    if (exp_rx) rxq.push_back(w);
  endtask

  // driver: one capture sample from the framer, model per R6/R7
  task automatic rxs(input logic [31:0] s, input bit keep);
    @(posedge clk); #1;
    rx_smp_valid = 1; rx_smp_data = s;
    @(posedge clk); #1;
    rx_smp_valid = 0;
    if (word_fmt == 3'd7) begin
      if (!bh) begin blo = s[15:0]; bh = 1; end
      else begin
        if (keep) rxq.push_back({s[15:0], blo});
        bh = 0;
      end
    end else if (keep) rxq.push_back(s & bmask(word_fmt));
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && (txq.size() != 0 || rxq.size() != 0); i++) @(negedge clk);
    chk("R1 playback scoreboard empty", txq.size(), 0);
    chk("R2 capture scoreboard empty", rxq.size(), 0);
  endtask

  // monitors: compare what the design emits against the queues
  always @(negedge clk) begin
    if (rst_n && tx_smp_valid && tx_smp_ready) begin
      if (txq.size() == 0) chk("R1 unexpected playback sample", tx_smp_data, 32'hxxxx_xxxx);
      else chk("R1 R6 R7 playback sample", tx_smp_data, txq.pop_front());
    end
    if (rst_n && host_rvalid && host_rready) begin
      if (rxq.size() == 0) chk("R2 unexpected capture word", host_rdata, 32'hxxxx_xxxx);
      else chk("R2 R6 R7 R9 capture word", host_rdata, rxq.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++; nmis++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R3 reset tx_slots", tx_slots, 16);
    chk("R3 reset rx_slots", rx_slots, 0);
    chk("R3 reset valids", {tx_smp_valid, host_rvalid}, 0);
    chk("R3 reset errors", {tx_err, rx_err}, 0);

    // playback held while disabled, attention levels (R1, R4, R10)
    tx_req_en = 1; tx_atn_lvl = 3;
    for (int i = 0; i < 3; i++) wr(32'h1000_0000 + i, 1, 0);
    @(negedge clk);
    chk("R3 tx_slots after 3", tx_slots, 13);
    chk("R4 tx_req 13>=12", tx_req, 1);
    chk("R10 tx_busy while disabled", tx_busy, 0);
    @(posedge clk); #1 tx_smp_ready = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 no sample while disabled", tx_smp_valid, 0);
    end
    chk("R8 no underrun while disabled", tx_err, 0);
    @(posedge clk); #1 tx_smp_ready = 0;
    for (int i = 3; i < 12; i++) wr(32'h1000_0000 + i, 1, 0);
    @(negedge clk);
    chk("R4 lvl3 with 4 empty", tx_req, 0);
    @(posedge clk); #1 tx_atn_lvl = 2;
    @(negedge clk); chk("R4 lvl2 with 4 empty", tx_req, 0);
    @(posedge clk); #1 tx_atn_lvl = 1;
    @(negedge clk); chk("R4 lvl1 with 4 empty", tx_req, 1);
    @(posedge clk); #1 tx_atn_lvl = 0; tx_req_en = 0;
    @(negedge clk);
    chk("R4 tx_ready lvl0", tx_ready, 1);
    chk("R4 request gated off", tx_req, 0);
    for (int i = 12; i < 16; i++) wr(32'h1000_0000 + i, 1, 0);
    @(negedge clk);
    chk("R1 wready low when full", host_wready, 0);
    chk("R4 tx_ready 0 empty slots", tx_ready, 0);
    @(posedge clk); #1 tx_enable = 1;
    @(negedge clk); chk("R10 tx_busy", tx_busy, 1);
    @(posedge clk); #1 tx_smp_ready = 1;
    drain();
    repeat (2) @(negedge clk);
    @(posedge clk); #1 tx_err_ie = 1;
    @(negedge clk);
    chk("R8 underrun flag", tx_err, 1);
    chk("R8 underrun irq", tx_err_irq, 1);
    @(posedge clk); #1 tx_smp_ready = 0; tx_err_clr = 1;
    @(posedge clk); #1 tx_err_clr = 0;
    @(negedge clk);
    chk("R8 cleared", tx_err, 0);
    chk("R8 irq cleared", tx_err_irq, 0);

    // playback formats (R6, R7)
    @(posedge clk); #1 tx_smp_ready = 1;
    for (int f = 0; f < 4; f++) begin
      @(posedge clk); #1 word_fmt = 3'(f);
      wr(32'hDEAD_BEEF, 1, 0);
      drain();
    end
    @(posedge clk); #1 word_fmt = 3'd7;
    wr(32'h2222_1111, 1, 0);
    wr(32'h4444_3333, 1, 0);
    drain();
    @(posedge clk); #1 tx_smp_ready = 0; tx_enable = 0; tx_err_clr = 1;
    @(posedge clk); #1 tx_err_clr = 0;

    // capture formats (R2, R6, R7)
    @(posedge clk); #1 rx_enable = 1; host_rready = 1; word_fmt = 3'd3;
    rxs(32'hA5A5_0001, 1); rxs(32'hA5A5_0002, 1); rxs(32'h8765_4321, 1);
    for (int f = 0; f < 3; f++) begin
      @(posedge clk); #1 word_fmt = 3'(f);
      rxs(32'h1234_5678, 1); rxs(32'hFFFF_FFFF, 1);
    end
    @(posedge clk); #1 word_fmt = 3'd7;
    rxs(32'h0000_AAAA, 1); rxs(32'hFFFF_BBBB, 1);
    drain();

    // capture stopped: samples ignored (R2)
    @(posedge clk); #1 rx_enable = 0; word_fmt = 3'd3; rx_smp_valid = 1; rx_smp_data = 32'h77;
    repeat (3) @(posedge clk);
    #1 rx_smp_valid = 0;
    @(negedge clk);
    chk("R2 disabled rx_slots", rx_slots, 0);
    chk("R2 disabled rvalid", host_rvalid, 0);
    chk("R10 rx_busy idle", rx_busy, 0);

    // overrun with attention boundary (R4, R8)
    @(posedge clk); #1 rx_enable = 1; host_rready = 0; rx_atn_lvl = 3; rx_req_en = 1; rx_err_ie = 1;
    for (int i = 0; i < 11; i++) rxs(32'h5000_0000 + i, 1);
    @(negedge clk);
    chk("R4 rx 11 below 12", rx_req, 0);
    rxs(32'h5000_000B, 1);
    @(negedge clk);
    chk("R4 rx 12 reaches 12", rx_req, 1);
    for (int i = 12; i < 16; i++) rxs(32'h5000_0000 + i, 1);
    @(negedge clk);
    chk("R3 rx_slots full", rx_slots, 16);
    chk("R8 no overrun yet", rx_err, 0);
    rxs(32'h5EAD_0017, 0);
    @(negedge clk);
    chk("R8 overrun flag", rx_err, 1);
    chk("R8 overrun irq", rx_err_irq, 1);
    chk("R8 dropped word not stored", rx_slots, 16);
    @(posedge clk); #1 host_rready = 1;
    drain();
    @(posedge clk); #1 rx_err_clr = 1;
    @(posedge clk); #1 rx_err_clr = 0;
    @(negedge clk); chk("R8 rx cleared", rx_err, 0);

    // flushes (R5)
    for (int i = 0; i < 5; i++) wr(32'h6000_0000 + i, 0, 0);
    @(posedge clk); #1 tx_flush = 1;
    @(posedge clk); #1 tx_flush = 0;
    @(negedge clk);
    chk("R5 tx flush slots", tx_slots, 16);
    @(posedge clk); #1 word_fmt = 3'd7;
    rxs(32'h0000_1234, 1);
    @(negedge clk); chk("R10 rx_busy half pending", rx_busy, 1);
    @(posedge clk); #1 rx_flush = 1;
    @(posedge clk); #1 rx_flush = 0; bh = 0;
    @(negedge clk);
    chk("R5 rx flush busy", rx_busy, 0);
    chk("R5 rx flush slots", rx_slots, 0);
    rxs(32'h0000_5555, 1); rxs(32'h0000_6666, 1);
    drain();

    // loopback (R9)
    @(posedge clk); #1 word_fmt = 3'd3; loop_enable = 1; tx_enable = 1; tx_smp_ready = 1;
    rx_smp_valid = 1; rx_smp_data = 32'hBAD0_BAD0;
    wr(32'hC0DE_0001, 1, 1); wr(32'hC0DE_0002, 1, 1); wr(32'h0BAD_F00D, 1, 1);
    drain();
    @(posedge clk); #1 rx_smp_valid = 0; tx_smp_ready = 0;
    @(negedge clk); chk("R9 nothing extra captured", rx_slots, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule